// File: doc/BRIEF.md
# Indirectly Addressed Interrupt Redirection Controller

This block turns a small set of interrupt input pins into interrupt messages. Each pin owns a 64-bit redirection entry. The entry sets the vector the pin delivers, a delivery-mode code, the input polarity, edge or level triggering, a mask bit, and a 16-bit destination made of a processor ID and an extended ID. Software never addresses an entry directly. It first writes a register index to a select register, then reads or writes a data window. A read-only identification word is reached the same way.

Inputs are synchronised and the polarity is applied to them. They are then treated as edge or level sources. A pin that is ready to deliver takes part in a fixed-priority selection. The selected pin's message is placed on an output port with a valid/ready handshake. An edge that arrives on a masked pin is lost for good. A level-triggered pin that has delivered stays quiet until software writes its vector to an end-of-interrupt register. Several level sources may share one pin, so the pin counts as active for as long as any of them drives it.

Top module: `irq_redirector`

## Requirements
- R1: After reset every entry reads back with only the mask bit set (low word 0x00010000, high word 0), the select register reads 0, and msg_valid is low.
- R2: Bus offsets are 0x00 for select, 0x10 for the window and 0x40 for end-of-interrupt. A window read returns data one cycle after the read strobe. Entry n uses index 0x10+2n for its low word and 0x11+2n for its high word. Low-word fields: vector [7:0], delivery mode [10:8], polarity [13], trigger [15] (1 = level) and mask [16]. All other low-word bits read as zero, and an index outside the map reads as zero.
- R3: The high word keeps the destination in bits [31:16] and reads back zero in bits [15:0]. A message carries its pin's destination on msg_dest.
- R4: Index 0x01 reads 0x00070021: version 0x21 in bits [7:0], highest entry index 7 in bits [23:16], and zero elsewhere. Writes to it have no effect.
- R5: Polarity 1 makes the pin active low. Only a change from inactive to active counts as an edge.
- R6: An unmasked edge-triggered pin delivers exactly one message, carrying its entry's vector and mode, for each inactive-to-active transition.
- R7: An edge that arrives while the pin is masked is dropped and is not delivered after the pin is unmasked. A masked pin is never granted.
- R8: An unmasked level-triggered pin delivers while active. It then delivers nothing more until an end-of-interrupt write whose bits [7:0] equal its vector. A write with any other vector has no effect. If the pin is still active after a matching write, it delivers again.
- R9: When several pins are ready together, the lowest-numbered pin is delivered first and only one pin is granted at a time.
- R10: While msg_valid is high and msg_ready is low, msg_valid, msg_vector, msg_dest and msg_mode hold steady.
- R11: A read-modify-write that changes only the mode field leaves the other fields unchanged, and the next message uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_in | input | 8 | Asynchronous interrupt pins |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination |
| msg_mode | output | 3 | Message delivery mode |

## Verification
The bench pulses a pin while it is masked and then unmasks it. A design that latched masked edges would deliver a late message at that point. On a level pin it withholds the end-of-interrupt, sends one with the wrong vector, and then sends the correct one. A design that re-armed too early, or matched the vector loosely, would send a duplicate or lose the redelivery. It raises two pins in the same cycle to catch a reversed priority. It stalls the receiver to catch message fields that change while waiting. It writes all-ones to the identification index and to reserved bits to catch registers that should not be writable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEST_W = 16;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] OFF_EOI    = 8'h40;

  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_TABLE   = 8'h10;

  localparam int LO_MODE_LSB = 8;
  localparam int LO_POL_BIT  = 13;
  localparam int LO_TRIG_BIT = 15;
  localparam int LO_MASK_BIT = 16;
  localparam int HI_DEST_LSB = 16;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       pol;
    logic       level;
    logic       mask;
  } rte_lo_t;

  localparam rte_lo_t RTE_LO_RESET = '{vector: 8'h00, mode: 3'b000, pol: 1'b0, level: 1'b0, mask: 1'b1};

  function automatic logic [31:0] lo_to_word(input rte_lo_t e);
    logic [31:0] w;
    w = '0;
    w[7:0] = e.vector;
    w[LO_MODE_LSB +: 3] = e.mode;
    w[LO_POL_BIT] = e.pol;
    w[LO_TRIG_BIT] = e.level;
    w[LO_MASK_BIT] = e.mask;
    return w;
  endfunction

  function automatic rte_lo_t word_to_lo(input logic [31:0] w);
    rte_lo_t e;
    e.vector = w[7:0];
    e.mode   = w[LO_MODE_LSB +: 3];
    e.pol    = w[LO_POL_BIT];
    e.level  = w[LO_TRIG_BIT];
    e.mask   = w[LO_MASK_BIT];
    return e;
  endfunction
endpackage

// File: rtl/irq_rte_file.sv
module irq_rte_file
  import irq_pkg::*;
#(
  parameter int         NPINS   = 8,
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output rte_lo_t           lo_q   [NPINS],
  output logic [DEST_W-1:0] dest_q [NPINS]
);
  localparam int         IDX_LAST  = int'(IDX_TABLE) + 2 * NPINS - 1;
  localparam logic [7:0] MAX_ENTRY = 8'(NPINS - 1);

  logic [7:0]  sel_q;
  logic [7:0]  rel;
  logic [7:0]  ent;
  logic        hi_word;
  logic        in_table;
  logic        win_wr;
  logic [31:0] win_rd;

  assign rel      = sel_q - IDX_TABLE;
  assign ent      = {1'b0, rel[7:1]};
  assign hi_word  = rel[0];
  assign in_table = (sel_q >= IDX_TABLE) && (int'(sel_q) <= IDX_LAST);
  assign win_wr   = wr_en && (addr == OFF_WINDOW) && in_table;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en && addr == OFF_SELECT) sel_q <= wdata[7:0];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g]   <= RTE_LO_RESET;
        dest_q[g] <= '0;
      end else if (win_wr && ent == 8'(g)) begin
        if (hi_word) dest_q[g] <= wdata[HI_DEST_LSB +: DEST_W];
        else         lo_q[g]   <= word_to_lo(wdata);
      end
    end

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lo_q[g].mask && lo_q[g].vector == 8'h00 && dest_q[g] == '0)) // R1
      else $error("entry %0d not masked after reset", g);
  end

  always_comb begin
    win_rd = '0;
    if (sel_q == IDX_VERSION) begin
      win_rd = {8'h00, MAX_ENTRY, 8'h00, VERSION};
    end else if (in_table) begin
      for (int i = 0; i < NPINS; i++) begin
        if (ent == 8'(i)) begin
          if (hi_word) win_rd = {dest_q[i], {(32 - DEST_W){1'b0}}};
          else         win_rd = lo_to_word(lo_q[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFF_SELECT: rdata <= {24'h0, sel_q};
        OFF_WINDOW: rdata <= win_rd;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic       pol,
  input  logic       level,
  input  logic       mask,
  input  logic [7:0] vector,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       grant,
  output logic       req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic active;
  logic prev_q;
  logic rise;
  logic pend_q;
  logic insvc_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign active = sync_q[SYNC_STAGES-1] ^ pol;
  assign rise   = active & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= active;
  end

  always_ff @(posedge clk) begin
    if (rst || level) pend_q <= 1'b0;
    else              pend_q <= (pend_q & ~grant) | (rise & ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !level) insvc_q <= 1'b0;
    else if (grant) insvc_q <= 1'b1;
    else if (eoi_valid && eoi_vector == vector) insvc_q <= 1'b0;
  end

  assign req = ~mask & (level ? (active & ~insvc_q) : pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  req,
  input  rte_lo_t           lo_q   [NPINS],
  input  logic [DEST_W-1:0] dest_q [NPINS],
  input  logic              msg_ready,
  output logic [NPINS-1:0]  grant,
  output logic              msg_valid,
  output logic [7:0]        msg_vector,
  output logic [DEST_W-1:0] msg_dest,
  output logic [2:0]        msg_mode
);
  logic              found;
  logic [7:0]        nxt_vec;
  logic [2:0]        nxt_mode;
  logic [DEST_W-1:0] nxt_dest;

  always_comb begin
    grant    = '0;
    found    = 1'b0;
    nxt_vec  = '0;
    nxt_mode = '0;
    nxt_dest = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (!found && !msg_valid && req[i]) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        nxt_vec  = lo_q[i].vector;
        nxt_mode = lo_q[i].mode;
        nxt_dest = dest_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_mode   <= '0;
      msg_dest   <= '0;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid  <= 1'b1;
      msg_vector <= nxt_vec;
      msg_mode   <= nxt_mode;
      msg_dest   <= nxt_dest;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) // R9
    else $error("more than one pin granted");

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (((grant - 1'b1) & req) == '0)) // R9
    else $error("higher pin granted over lower one");

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
      && $stable(msg_dest) && $stable(msg_mode))) // R10
    else $error("message changed while stalled");
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_pkg::*;
#(
  parameter int         NPINS       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VERSION     = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_in,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [DEST_W-1:0] msg_dest,
  output logic [2:0]        msg_mode
);
  rte_lo_t           lo_q   [NPINS];
  logic [DEST_W-1:0] dest_q [NPINS];
  logic [NPINS-1:0]  req;
  logic [NPINS-1:0]  grant;
  logic [NPINS-1:0]  mask_vec;
  logic              eoi_valid;

  assign eoi_valid = bus_wr_en && (bus_addr == OFF_EOI);

  irq_rte_file #(.NPINS(NPINS), .VERSION(VERSION)) u_rte (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .lo_q(lo_q), .dest_q(dest_q)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst(rst), .pin_raw(irq_in[g]),
      .pol(lo_q[g].pol), .level(lo_q[g].level), .mask(lo_q[g].mask),
      .vector(lo_q[g].vector), .eoi_valid(eoi_valid),
      .eoi_vector(bus_wdata[7:0]), .grant(grant[g]), .req(req[g])
    );
    assign mask_vec[g] = lo_q[g].mask;
  end

  irq_arbiter #(.NPINS(NPINS)) u_arb (
    .clk(clk), .rst(rst), .req(req), .lo_q(lo_q), .dest_q(dest_q),
    .msg_ready(msg_ready), .grant(grant), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode)
  );

  AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (grant & mask_vec) == '0) // R7
    else $error("masked pin granted");
endmodule

// File: tb/irq_redirector_tb.sv
`timescale 1ns/1ps
module irq_redirector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, msg_ready = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pins = '0;
  logic        msg_valid;
  logic [7:0]  msg_vector;
  logic [15:0] msg_dest;
  logic [2:0]  msg_mode;

  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_redirector u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(pins),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_mode(msg_mode)
  );

  // {index, write data}
  localparam logic [39:0] TABLE [6] = '{
    {8'h01, 32'hFFFF_FFFF},
    {8'h10, 32'hFFFF_FFFF},
    {8'h11, 32'h1234_ABCD},
    {8'h1F, 32'hBEEF_0001},
    {8'h1E, 32'h0001_4E5A},
    {8'h05, 32'hFFFF_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx});
    bus_wr(8'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx});
    @(negedge clk); rd_en = 1'b1; addr = 8'h10;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_msg(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  function automatic logic [31:0] expect_rd(input logic [7:0] idx, input logic [31:0] d);
    if (idx == 8'h01) return 32'h0007_0021;
    if (idx >= 8'h10 && idx <= 8'h1F) return idx[0] ? (d & 32'hFFFF_0000) : (d & 32'h0001_A7FF);
    return 32'h0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchecks++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 msg_valid", {31'h0, msg_valid}, 32'h0);
    reg_rd(8'h10, d); check("R1 low word", d, 32'h0001_0000);
    reg_rd(8'h17, d); check("R1 high word", d, 32'h0);
    @(negedge clk); rd_en = 1'b1; addr = 8'h00;
    @(negedge clk); rd_en = 1'b0;
    check("R1 select", rdata, 32'h0000_0017);

    // R2 R3 R4 vector table walk
    foreach (TABLE[k]) begin
      reg_wr(TABLE[k][39:32], TABLE[k][31:0]);
      reg_rd(TABLE[k][39:32], d);
      check("R2/R3/R4 window", d, expect_rd(TABLE[k][39:32], TABLE[k][31:0]));
    end

    // R6 R3 edge pin 0 with mode and destination; R10 stall
    reg_wr(8'h10, 32'h0000_0141);
    reg_wr(8'h11, 32'hAB12_0000);
    @(negedge clk); pins[0] = 1'b1;
    wait_msg(seen);
    check("R6 delivered", {31'h0, seen}, 32'h1);
    check("R6 vector", {24'h0, msg_vector}, 32'h41);
    check("R6 mode", {29'h0, msg_mode}, 32'h1);
    check("R3 dest", {16'h0, msg_dest}, 32'hAB12);
    repeat (3) @(negedge clk);
    check("R10 held valid", {31'h0, msg_valid}, 32'h1);
    check("R10 held vector", {24'h0, msg_vector}, 32'h41);
    accept();
    quiet(8, seen);
    check("R6 single per edge", {31'h0, seen}, 32'h0);
    pins[0] = 1'b0;

    // R5 active-low pin 1
    pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(8'h12, 32'h0000_2152);
    quiet(6, seen);
    check("R5 high is idle", {31'h0, seen}, 32'h0);
    pins[1] = 1'b0;
    wait_msg(seen);
    check("R5 falling delivers", {24'h0, seen ? msg_vector : 8'h00}, 32'h52);
    accept();
    pins[1] = 1'b1;
    quiet(8, seen);
    check("R5 rising ignored", {31'h0, seen}, 32'h0);

    // R7 masked edge dropped
    reg_wr(8'h14, 32'h0001_0063);
    pins[2] = 1'b1; repeat (4) @(negedge clk);
    pins[2] = 1'b0; repeat (4) @(negedge clk);
    reg_wr(8'h14, 32'h0000_0063);
    quiet(8, seen);
    check("R7 no late delivery", {31'h0, seen}, 32'h0);
    pins[2] = 1'b1;
    wait_msg(seen);
    check("R7 unmasked edge", {24'h0, seen ? msg_vector : 8'h00}, 32'h63);
    accept();
    pins[2] = 1'b0;

    // R8 level pin 3 with end-of-interrupt
    reg_wr(8'h16, 32'h0000_8074);
    pins[3] = 1'b1;
    wait_msg(seen);
    check("R8 level delivers", {24'h0, seen ? msg_vector : 8'h00}, 32'h74);
    accept();
    quiet(8, seen);
    check("R8 held until EOI", {31'h0, seen}, 32'h0);
    bus_wr(8'h40, 32'h75);
    quiet(8, seen);
    check("R8 wrong vector EOI", {31'h0, seen}, 32'h0);
    bus_wr(8'h40, 32'h74);
    wait_msg(seen);
    check("R8 redeliver after EOI", {31'h0, seen}, 32'h1);
    accept();
    pins[3] = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr(8'h40, 32'h74);
    quiet(8, seen);
    check("R8 inactive after EOI", {31'h0, seen}, 32'h0);

    // R9 simultaneous pins 4 and 6
    reg_wr(8'h1C, 32'h0000_0086);
    reg_wr(8'h18, 32'h0000_0084);
    @(negedge clk); pins[4] = 1'b1; pins[6] = 1'b1;
    wait_msg(seen);
    check("R9 lowest first", {24'h0, seen ? msg_vector : 8'h00}, 32'h84);
    accept();
    wait_msg(seen);
    check("R9 next pin", {24'h0, seen ? msg_vector : 8'h00}, 32'h86);
    accept();
    pins[4] = 1'b0; pins[6] = 1'b0;

    // R11 mode-only read-modify-write
    reg_rd(8'h18, d);
    reg_wr(8'h18, (d & ~32'h0000_0700) | 32'h0000_0200);
    reg_rd(8'h18, d);
    check("R11 rmw preserved", d, 32'h0000_0284);
    repeat (4) @(negedge clk);
    pins[4] = 1'b1;
    wait_msg(seen);
    check("R11 new mode used", {29'h0, seen ? msg_mode : 3'b000}, 32'h2);
    accept();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule